// File: doc/BRIEF.md
# Multi-Domain Ratio-Coded Clock Enable Generator

This block runs on one fast source clock and derives single-cycle enable pulses for four main clock domains: processor, fast bus, slow bus and memory. It also derives two auxiliary pulses for a display clock and a USB clock. The auxiliary pulses are counted from a secondary tick stream, which runs either at the full source rate or at half of it. All of the settings live in one 32-bit control word that a simple write/read port can reach.

Each main domain takes a 4-bit ratio code that selects a divisor from a non-uniform set. The display and USB dividers are plain binary fields, and each divides by its field value plus one. A write always lands in the control word, but the dividers only adopt new settings when the write carries the change-enable flag. Even then the settings are applied at a point where every main-domain counter wraps in the same cycle, so that no domain ever emits a shortened interval.

The update logic is a two-state machine:
- ST_RUN: the active settings are frozen. A write with the change-enable flag set moves it to ST_PEND.
- ST_PEND: a change is waiting. In the first cycle where all four main enables are high, the control word is copied into the active settings. The machine then returns to ST_RUN, unless that same cycle carries another write with the flag set, in which case it stays in ST_PEND.
- Cancel: a write with the flag clear while in ST_PEND returns the machine to ST_RUN without applying anything.

Top module: `clkratio_gen`

## Requirements
- R1: After reset the control word reads 0. All four main enables are high every cycle (divide by 1). The display and USB enables pulse once every 2 cycles, because the secondary source is at half rate.
- R2: A write stores all 32 bits of wr_data in the control word. The new value appears on rd_data in the cycle after the write.
- R3: The ratio fields sit at bits [3:0] (processor), [7:4] (fast bus), [11:8] (slow bus) and [15:12] (memory). Codes 0 to 9 give a pulse period of 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 source cycles respectively.
- R4: A ratio code from 10 to 15 gives a period of 32 cycles.
- R5: For a divisor above 1, each enable pulse lasts exactly one source cycle, and this holds for odd divisors such as 3 as well.
- R6: A write with bit 22 clear changes rd_data but leaves every output period unchanged.
- R7: A change written with bit 22 set takes effect only at a cycle where all four main enables are high. Across the switch, every interval between pulses of a main domain equals either the old divisor or the new one.
- R8: The display field at bits [20:16] gives a period of (field+1) secondary ticks.
- R9: The USB field at bits [28:23] gives a period of (field+1) secondary ticks.
- R10: Bit 21 set makes the secondary tick fire on every source cycle. Bit 21 clear makes it fire on every second source cycle, which doubles the display and USB periods.
- R11: A write with bit 22 clear, made while a change is still waiting, discards that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value written to the control word |
| rd_data | output | 32 | Current control word |
| en_cpu | output | 1 | Processor domain enable pulse |
| en_hbus | output | 1 | Fast bus domain enable pulse |
| en_pbus | output | 1 | Slow bus domain enable pulse |
| en_mem | output | 1 | Memory domain enable pulse |
| en_disp | output | 1 | Display clock enable pulse |
| en_usb | output | 1 | USB clock enable pulse |

## Verification
The bench measures the interval between pulses on every output for several control words. These words cover every code in the divisor table, the saturating codes, the extreme display and USB fields, and both secondary-rate settings. A design with a wrong table entry or a missing saturation shows up as a wrong period. A design that stretches a pulse on an odd divisor shows up as a second high cycle. To probe cancellation, the bench writes a change in the cycle right after an alignment point and cancels it before the next one. A design that applies changes immediately, or that ignores the cancel, would then show the new period. The bench also watches every interval across a live ratio switch. A design that reloads counters at an arbitrary cycle would produce an interval that matches neither the old divisor nor the new one.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

    localparam int CTRL_W     = 32;
    localparam int RATIO_W    = 4;
    localparam int NUM_DOM    = 4;
    localparam int DISP_W     = 5;
    localparam int USB_W      = 6;
    localparam int MAX_DIV    = 32;
    localparam int MAIN_CNT_W = $clog2(MAX_DIV);

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } upd_state_t;

    // Ratio code to terminal count (divisor minus one); saturates above code 9.
    function automatic logic [MAIN_CNT_W-1:0] ratio_limit(input logic [RATIO_W-1:0] code);
        logic [MAIN_CNT_W-1:0] lim;
        unique case (code)
            4'd0:    lim = MAIN_CNT_W'(0);
            4'd1:    lim = MAIN_CNT_W'(1);
            4'd2:    lim = MAIN_CNT_W'(2);
            4'd3:    lim = MAIN_CNT_W'(3);
            4'd4:    lim = MAIN_CNT_W'(5);
            4'd5:    lim = MAIN_CNT_W'(7);
            4'd6:    lim = MAIN_CNT_W'(11);
            4'd7:    lim = MAIN_CNT_W'(15);
            4'd8:    lim = MAIN_CNT_W'(23);
            default: lim = MAIN_CNT_W'(MAX_DIV - 1);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/clkratio_ctrl.sv
module clkratio_ctrl
    import clkratio_pkg::*;
#(
    parameter int CW  = CTRL_W,
    parameter int RW  = RATIO_W,
    parameter int ND  = NUM_DOM,
    parameter int DW  = DISP_W,
    parameter int UW  = USB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_data,
    input  logic             align,
    output logic [CW-1:0]    ctrl_q,
    output logic [ND*RW-1:0] act_ratios,
    output logic [DW-1:0]    act_disp,
    output logic [UW-1:0]    act_usb,
    output logic             act_full,
    output logic             load,
    output logic             pend
);
    localparam int DISP_LSB = ND * RW;
    localparam int FULL_BIT = DISP_LSB + DW;
    localparam int CE_BIT   = FULL_BIT + 1;
    localparam int USB_LSB  = CE_BIT + 1;

    upd_state_t state_q, state_d;
    logic       wr_ce;

    assign wr_ce = wr_en && wr_data[CE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wr_ce) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (align)      state_d = wr_ce ? ST_PEND : ST_RUN;
                else if (wr_en) state_d = wr_ce ? ST_PEND : ST_RUN;
            end
        endcase
    end

    always_comb begin
        load = 1'b0;
        pend = 1'b0;
        unique case (state_q)
            ST_RUN:  ;
            ST_PEND: begin
                pend = 1'b1;
                load = align;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_ratios <= '0;
            act_disp   <= '0;
            act_usb    <= '0;
            act_full   <= 1'b0;
        end else if (load) begin
            act_ratios <= ctrl_q[ND*RW-1:0];
            act_disp   <= ctrl_q[DISP_LSB +: DW];
            act_usb    <= ctrl_q[USB_LSB +: UW];
            act_full   <= ctrl_q[FULL_BIT];
        end
    end

endmodule

// File: rtl/clkratio_domain.sv
module clkratio_domain
    import clkratio_pkg::*;
#(
    parameter int RW = RATIO_W,
    parameter int CNTW = MAIN_CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   code,
    output logic            en,
    output logic [CNTW-1:0] lim
);
    logic [CNTW-1:0] cnt_q;

    assign lim = ratio_limit(code);
    assign en  = (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cnt_q <= '0;
        else if (en) cnt_q <= '0;
        else         cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/clkratio_tickdiv.sv
module clkratio_tickdiv #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] lim,
    output logic         en
);
    logic [W-1:0] cnt_q;

    assign en = tick && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (en)     cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/clkratio_aux.sv
module clkratio_aux
    import clkratio_pkg::*;
#(
    parameter int DW = DISP_W,
    parameter int UW = USB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          full,
    input  logic [DW-1:0] disp_lim,
    input  logic [UW-1:0] usb_lim,
    output logic          en_disp,
    output logic          en_usb
);
    logic half_ph_q;
    logic tick;

    assign tick = full || half_ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    half_ph_q <= 1'b0;
        else if (load) half_ph_q <= 1'b0;
        else           half_ph_q <= ~half_ph_q;
    end

    clkratio_tickdiv #(.W(DW)) u_disp (
        .clk(clk), .rst_n(rst_n), .clr(load), .tick(tick),
        .lim(disp_lim), .en(en_disp)
    );

    clkratio_tickdiv #(.W(UW)) u_usb (
        .clk(clk), .rst_n(rst_n), .clr(load), .tick(tick),
        .lim(usb_lim), .en(en_usb)
    );

endmodule

// File: rtl/clkratio_gen.sv
module clkratio_gen
    import clkratio_pkg::*;
#(
    parameter int CW = CTRL_W,
    parameter int RW = RATIO_W,
    parameter int DW = DISP_W,
    parameter int UW = USB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] rd_data,
    output logic          en_cpu,
    output logic          en_hbus,
    output logic          en_pbus,
    output logic          en_mem,
    output logic          en_disp,
    output logic          en_usb
);
    localparam int ND = NUM_DOM;

    logic [ND*RW-1:0]     act_ratios;
    logic [DW-1:0]        act_disp;
    logic [UW-1:0]        act_usb;
    logic                 act_full;
    logic                 upd_load;
    logic                 upd_pend;
    logic [ND-1:0]        dom_en;
    logic [MAIN_CNT_W-1:0] dom_lim [ND];
    logic                 align;

    assign align = &dom_en;

    clkratio_ctrl #(.CW(CW), .RW(RW), .ND(ND), .DW(DW), .UW(UW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .align(align), .ctrl_q(rd_data), .act_ratios(act_ratios),
        .act_disp(act_disp), .act_usb(act_usb), .act_full(act_full),
        .load(upd_load), .pend(upd_pend)
    );

    for (genvar d = 0; d < ND; d++) begin : g_dom
        clkratio_domain #(.RW(RW), .CNTW(MAIN_CNT_W)) u_dom (
            .clk(clk), .rst_n(rst_n),
            .code(act_ratios[d*RW +: RW]),
            .en(dom_en[d]), .lim(dom_lim[d])
        );
    end

    clkratio_aux #(.DW(DW), .UW(UW)) u_aux (
        .clk(clk), .rst_n(rst_n), .load(upd_load), .full(act_full),
        .disp_lim(act_disp), .usb_lim(act_usb),
        .en_disp(en_disp), .en_usb(en_usb)
    );

    assign en_cpu  = dom_en[0];
    assign en_hbus = dom_en[1];
    assign en_pbus = dom_en[2];
    assign en_mem  = dom_en[3];

endmodule

// File: rtl/clkratio_gen_chk.sv
module clkratio_gen_chk
    import clkratio_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [CTRL_W-1:0]     wr_data,
    input logic [CTRL_W-1:0]     rd_data,
    input logic                  en_cpu,
    input logic                  en_hbus,
    input logic                  en_pbus,
    input logic                  en_mem,
    input logic                  en_disp,
    input logic                  upd_load,
    input logic                  upd_pend,
    input logic                  act_full,
    input logic [MAIN_CNT_W-1:0] cpu_lim,
    input logic [CTRL_W-1:0]     act_word
);
    localparam int CE_BIT = NUM_DOM * RATIO_W + DISP_W + 1;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rd_data == '0));

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    // R6
    hold_without_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pend && !(wr_en && wr_data[CE_BIT])) |=> $stable(act_word));

    // R7
    align_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_word != $past(act_word)) |-> $past(en_cpu && en_hbus && en_pbus && en_mem));

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cpu && (cpu_lim != '0) && !upd_load) |=> !en_cpu);

    // R10
    half_rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_disp && !act_full && !upd_load) |=> !en_disp);

endmodule

bind clkratio_gen clkratio_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .en_cpu(en_cpu), .en_hbus(en_hbus),
    .en_pbus(en_pbus), .en_mem(en_mem), .en_disp(en_disp),
    .upd_load(upd_load), .upd_pend(upd_pend), .act_full(act_full),
    .cpu_lim(dom_lim[0]),
    .act_word({3'b000, act_usb, 1'b0, act_full, act_disp, act_ratios})
);

// File: tb/clkratio_gen_test.sv
module clkratio_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        en_cpu, en_hbus, en_pbus, en_mem, en_disp, en_usb;
    logic [5:0]  ens;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    clkratio_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .en_cpu(en_cpu), .en_hbus(en_hbus),
        .en_pbus(en_pbus), .en_mem(en_mem), .en_disp(en_disp), .en_usb(en_usb)
    );

    assign ens = {en_usb, en_disp, en_mem, en_pbus, en_hbus, en_cpu};

    localparam logic [31:0] CE = 32'h0040_0000;

    localparam int NV = 4;
    localparam logic [31:0] VEC_WORD [NV] = '{
        32'h0043_4321,
        32'h02E0_8765,
        32'h1FFF_0FA9,
        32'hA4C4_3C02
    };
    // periods: cpu, hbus, pbus, mem, disp, usb
    localparam int VEC_PER [NV][6] = '{
        '{2, 3, 4, 6, 8, 2},
        '{8, 12, 16, 24, 1, 6},
        '{32, 32, 32, 1, 32, 64},
        '{3, 1, 32, 4, 10, 20}
    };
    localparam string REQ_OF [6] = '{"R3", "R3", "R3", "R3", "R8", "R9"};

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int sel, output int gap);
        int n;
        n = 0;
        while (!ens[sel] && n < 400) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!ens[sel] && n < 400);
        gap = n;
    endtask

    task automatic run_all();
        int g;
        bit all_ok;
        bit saw_new;

        // R1: reset state
        check(rd_data == 32'd0, "R1 readback", rd_data, 0);
        all_ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (ens[3:0] != 4'hF) all_ok = 1'b0;
            @(negedge clk);
        end
        check(all_ok, "R1 main enables", ens[3:0], 15);
        measure(4, g); check(g == 2, "R1 disp period", g, 2);
        measure(5, g); check(g == 2, "R1 usb period", g, 2);

        // table walk: R2, R3, R4 (vector 2), R5 (vector 3), R8, R9, R10
        for (int v = 0; v < NV; v++) begin
            wr(VEC_WORD[v]);
            check(rd_data == VEC_WORD[v], "R2 readback", rd_data, VEC_WORD[v]);
            idle(250);
            for (int s = 0; s < 6; s++) begin
                measure(s, g);
                check(g == VEC_PER[v][s], REQ_OF[s], g, VEC_PER[v][s]);
            end
        end

        // R5: odd divisor pulse one cycle wide (cpu still at 3)
        while (!en_cpu) @(negedge clk);
        @(negedge clk);
        check(en_cpu == 1'b0, "R5 width", en_cpu, 0);

        // R6: write without change-enable leaves periods alone
        wr(32'h0000_0004);
        check(rd_data == 32'h0000_0004, "R6 readback", rd_data, 4);
        idle(250);
        measure(0, g); check(g == 3, "R6 cpu held", g, 3);
        measure(3, g); check(g == 4, "R6 mem held", g, 4);

        // R4: saturating code 13 on cpu
        wr(CE | 32'h0000_000D);
        idle(250);
        measure(0, g); check(g == 32, "R4 code13", g, 32);

        // R10: full versus half secondary rate with display field 2
        wr(CE | 32'h0022_0000);
        idle(250);
        measure(4, g); check(g == 3, "R10 full", g, 3);
        wr(CE | 32'h0002_0000);
        idle(250);
        measure(4, g); check(g == 6, "R10 half", g, 6);

        // R11: cancel a pending change before the next alignment point
        wr(CE | 32'h0000_0029);
        idle(250);
        while (!(en_cpu && en_hbus)) @(negedge clk);
        wr(CE | 32'h0000_0020);
        wr(32'h0000_0020);
        idle(250);
        measure(0, g); check(g == 32, "R11 cancel", g, 32);

        // R7: live switch from 32 to 2 on cpu; intervals must be old or new
        wr(CE | 32'h0000_0021);
        while (!en_cpu) @(negedge clk);
        all_ok  = 1'b1;
        saw_new = 1'b0;
        for (int i = 0; i < 60; i++) begin
            measure(0, g);
            if (g != 32 && g != 2) all_ok = 1'b0;
            if (g == 2) saw_new = 1'b1;
        end
        check(all_ok, "R7 interval set", g, 2);
        check(saw_new, "R7 applied", saw_new, 1);
        measure(1, g); check(g == 3, "R7 hbus", g, 3);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                idle(150000);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule